// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Split Registers

This block is a byte-wide asynchronous serial port that sits on a simple valid/ready memory bus. Software sees three word registers inside a 4 KB window: a write-only transmit register, a read-only receive register whose read consumes one byte, and a read-only status word. The serial line format is one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. The line rests high between frames.

The bit period is set by the `CLKS_PER_BIT` parameter. A 50 MHz clock at 115200 baud gives about 434 clocks per bit, and that is the default. Received bytes go into a 16-entry queue. Firmware polls the status word: it waits for the transmitter to be free before writing a byte, and it drains the queue while data is present.

A bus request is accepted on the first clock edge where `bus_valid_i` is high and `bus_ready_o` is low. `bus_ready_o` then goes high for exactly one cycle, and the read data is valid in that same cycle. Only bits 11:2 of the address select a register inside the window.

Top module: `uart_mmio`

## Requirements
- R1: A request whose address lies outside 0x1000_0000..0x1000_0FFF changes no state, starts no frame and reads as 0. It still receives its one-cycle ready.
- R2: `bus_ready_o` is high for exactly one cycle, one clock after a request is accepted. Read data is valid while ready is high.
- R3: A write to offset 0x0 sends bits 7:0 of the write data as one frame: a low start bit, data bits LSB first, then a high stop bit. Each bit lasts `CLKS_PER_BIT` clocks, and the line rests high when no frame is being sent.
- R4: A write to offset 0x0 while the transmitter is busy is dropped. No second frame is sent.
- R5: Offset 0x8 is the status word. Bit 0 is high while a frame is being sent. Bit 1 is high while the receive queue holds data. Bits 31:2 read 0. Writes to 0x8 and 0x4 have no effect.
- R6: A read of offset 0x4 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes that byte from the queue.
- R7: A read of offset 0x4 with an empty queue returns 0 and changes nothing.
- R8: The receiver synchronises `rx_i` through two flip-flops and samples each bit at its middle. It keeps a frame only if the stop bit is high. A frame with a low stop bit is discarded.
- R9: The receive queue holds 16 bytes in arrival order. A byte that completes while the queue is full is dropped, and the 16 stored bytes are kept.
- R10: After reset, `tx_o` is high, `bus_ready_o` is low and the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Request valid |
| bus_addr_i | input | 32 | Byte address of the request |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_rdata_o | output | 32 | Read data, valid while ready is high |
| bus_ready_o | output | 1 | One-cycle completion pulse |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench writes a second byte while a frame is still going out. A design that does not drop this write would corrupt the frame on the line or send an extra frame. It reads the empty queue and reads past the last stored byte. A design that pops on empty would report data that is not there, or would upset the queue count.

It sends a frame with a low stop bit, which a receiver that ignores the stop bit would store as a byte. It sends 17 bytes into the 16-entry queue. A design that overwrites on a full queue would lose the oldest byte or return the bytes out of order. Accesses just outside the window and writes to the read-only registers must leave the line and the status unchanged.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

    // register word index, taken from address bits 11:2
    localparam logic [9:0] WORD_TXD  = 10'd0;
    localparam logic [9:0] WORD_RXD  = 10'd1;
    localparam logic [9:0] WORD_STAT = 10'd2;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

endpackage

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_mm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       tx_o
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    shift;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (start_i) begin
                    d.st    = TX_START;
                    d.cnt   = '0;
                    d.shift = data_i;
                end
            end
            TX_START: begin
                if (q.cnt == LAST) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.st   = TX_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            TX_DATA: begin
                if (q.cnt == LAST) begin
                    d.cnt   = '0;
                    d.shift = {1'b0, q.shift[7:1]};
                    if (q.bitn == 3'd7) d.st = TX_STOP;
                    else                d.bitn = q.bitn + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            TX_STOP: begin
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    d.st  = TX_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: TX_IDLE, cnt: '0, bitn: '0, shift: '0};
        else     q <= d;
    end

    assign busy_o = (q.st != TX_IDLE);
    assign tx_o   = (q.st == TX_START) ? 1'b0 :
                    (q.st == TX_DATA)  ? q.shift[0] : 1'b1;

    // R3: line rests high whenever no frame is in flight
    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> tx_o);
    // R3: a frame opens with a low start bit
    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !tx_o);
    // R4: a start request during a frame does not reload the shifter
    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && q.st == TX_START && q.cnt != LAST) |=> $stable(q.shift));

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_mm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 434
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    output logic       push_o,
    output logic [7:0] data_o
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID  = CW'((CLKS_PER_BIT / 2) - 1);

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    shift;
        logic          push;
    } rx_regs_t;

    rx_regs_t q, d;
    logic     rxs;

    assign rxs = q.sync[1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rx_i};
        d.push = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (!rxs) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (q.cnt == MID) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.st   = rxs ? RX_IDLE : RX_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (q.cnt == LAST) begin
                    d.cnt   = '0;
                    d.shift = {rxs, q.shift[7:1]};
                    if (q.bitn == 3'd7) d.st = RX_STOP;
                    else                d.bitn = q.bitn + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (q.cnt == LAST) begin
                    d.cnt = '0;
                    if (rxs) begin
                        d.push = 1'b1;
                        d.st   = RX_IDLE;
                    end else begin
                        d.st = RX_BREAK;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_BREAK: begin
                if (rxs) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{sync: 2'b11, st: RX_IDLE, cnt: '0, bitn: '0, shift: '0, push: 1'b0};
        else     q <= d;
    end

    assign push_o = q.push;
    assign data_o = q.shift;

    // R8: a byte is delivered only out of a stop bit sampled high
    p_push_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
        push_o |-> ($past(q.st) == RX_STOP && $past(rxs)));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CNT_FULL);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[q.rd];

    always_comb begin
        d = q;
        if (do_push) d.wr = (q.wr == PTR_LAST) ? '0 : q.wr + 1'b1;
        if (do_pop)  d.rd = (q.rd == PTR_LAST) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{wr: '0, rd: '0, cnt: '0};
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= data_i;
    end

    // R9: a push into a full queue leaves it full and does not wrap the count
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> (full_o && $stable(q.wr)));
    // R7: a pop of an empty queue leaves it empty
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> (empty_o && $stable(q.rd)));

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
    import uart_mm_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR    = 32'h1000_0000,
    parameter int          CLKS_PER_BIT = 434,
    parameter int          RX_DEPTH     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid_i,
    input  logic [31:0] bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    input  logic        bus_we_i,
    output logic [31:0] bus_rdata_o,
    output logic        bus_ready_o,
    output logic        tx_o,
    input  logic        rx_i
);
    typedef struct packed {
        logic        ready;
        logic [31:0] rdata;
        logic        miss;
    } bus_regs_t;

    bus_regs_t q, d;

    logic       accept, hit;
    logic [9:0] word;
    logic       tx_start, tx_busy;
    logic       rx_push, rx_pop, rx_empty, rx_full;
    logic [7:0] rx_byte, rx_head;

    assign accept   = bus_valid_i && !q.ready;
    assign hit      = (bus_addr_i[31:12] == BASE_ADDR[31:12]);
    assign word     = bus_addr_i[11:2];
    assign tx_start = accept && bus_we_i && hit && (word == WORD_TXD);
    assign rx_pop   = accept && !bus_we_i && hit && (word == WORD_RXD) && !rx_empty;

    always_comb begin
        d       = q;
        d.ready = accept;
        d.miss  = accept && !hit;
        if (accept) begin
            d.rdata = '0;
            if (!bus_we_i && hit) begin
                case (word)
                    WORD_RXD:  d.rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
                    WORD_STAT: d.rdata = {30'd0, !rx_empty, tx_busy};
                    default:   d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{ready: 1'b0, rdata: '0, miss: 1'b0};
        else     q <= d;
    end

    assign bus_ready_o = q.ready;
    assign bus_rdata_o = q.rdata;

    uart_tx_fsm #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start),
        .data_i  (bus_wdata_i[7:0]),
        .busy_o  (tx_busy),
        .tx_o    (tx_o)
    );

    uart_rx_fsm #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .rx_i   (rx_i),
        .push_o (rx_push),
        .data_o (rx_byte)
    );

    uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (rx_push),
        .data_i  (rx_byte),
        .pop_i   (rx_pop),
        .head_o  (rx_head),
        .empty_o (rx_empty),
        .full_o  (rx_full)
    );

    // R2: completion is a single-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ready_o |=> !bus_ready_o);
    // R1: requests outside the window read as zero
    p_miss_reads_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_ready_o && q.miss) |-> (bus_rdata_o == 32'd0));
    // R9: a full queue cannot also be empty
    p_full_not_empty_r9: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !rx_empty);

endmodule

// File: tb/sim_uart_mmio.sv
module sim_uart_mmio;
    localparam int CPB = 16;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        ready;
    logic        tx;
    logic        rx = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          chk;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t       rd_q[$];
    logic [7:0] tx_q[$];
    exp_t       cur;

    always #2 clk = ~clk;

    uart_mmio #(.BASE_ADDR(BASE), .CLKS_PER_BIT(CPB), .RX_DEPTH(16)) u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_valid_i (valid),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .bus_ready_o (ready),
        .tx_o        (tx),
        .rx_i        (rx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one bus request; reads push an expected item for the monitor
    task automatic bus(input logic [31:0] a, input logic [31:0] dat, input logic w,
                       input bit c, input logic [31:0] e, input string req);
        @(negedge clk);
        valid = 1'b1; addr = a; wdata = dat; we = w;
        rd_q.push_back('{chk: c, val: e, req: req});
        @(negedge clk);
        while (!ready) @(negedge clk);
        valid = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R2 ready single cycle", {31'd0, ready}, 32'd0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] dat);
        bus(a, dat, 1'b1, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string req);
        bus(a, '0, 1'b0, 1'b1, e, req);
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        rx = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx = stop;
        repeat (CPB) @(negedge clk);
        rx = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    // monitor: bus completions
    always @(negedge clk) begin
        if (!rst && ready) begin
            if (rd_q.size() == 0) begin
                check("R2 unexpected ready", 32'd1, 32'd0);
            end else begin
                cur = rd_q.pop_front();
                if (cur.chk) check(cur.req, rdata, cur.val);
            end
        end
    end

    // monitor: serial transmit line, sampled mid-bit (R3)
    initial begin
        logic [7:0] got;
        logic [7:0] exp_b;
        forever begin
            @(negedge clk);
            if (!rst && tx == 1'b0) begin
                repeat (CPB / 2) @(negedge clk);
                check("R3 start bit", {31'd0, tx}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    got[i] = tx;
                end
                repeat (CPB) @(negedge clk);
                check("R3 stop bit", {31'd0, tx}, 32'd1);
                if (tx_q.size() == 0) begin
                    check("R4 R1 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
                end else begin
                    exp_b = tx_q.pop_front();
                    check("R3 frame data", {24'd0, got}, {24'd0, exp_b});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 tx idle high", {31'd0, tx}, 32'd1);
        check("R10 ready low", {31'd0, ready}, 32'd0);
        rd(BASE + 32'h8, 32'd0, "R10 status after reset");

        // R7: empty pop returns 0 and changes nothing
        rd(BASE + 32'h4, 32'd0, "R7 empty read");
        rd(BASE + 32'h8, 32'd0, "R7 status still empty");

        // R3 / R4: send a byte, write again while busy
        tx_q.push_back(8'hA5);
        wr(BASE + 32'h0, 32'hFFFF_FFA5);
        rd(BASE + 32'h8, 32'd1, "R5 tx busy bit");
        wr(BASE + 32'h0, 32'h0000_003C);   // R4: dropped
        repeat (13 * CPB) @(negedge clk);
        rd(BASE + 32'h8, 32'd0, "R5 tx idle again");
        check("R4 no queued frames", tx_q.size(), 32'd0);

        // R1: outside window
        wr(BASE + 32'h1000, 32'h77);
        wr(32'h2000_0000, 32'h66);
        rd(32'h1000_1008, 32'd0, "R1 miss read");
        rd(BASE + 32'h8, 32'd0, "R1 status untouched");
        tx_q.push_back(8'h5A);
        wr(BASE + 32'h0, 32'h5A);
        repeat (13 * CPB) @(negedge clk);
        check("R1 only in-window frame", tx_q.size(), 32'd0);

        // R6 / R8: receive two bytes
        send(8'h3C, 1'b1);
        send(8'h81, 1'b1);
        rd(BASE + 32'h8, 32'd2, "R5 rx valid bit");
        rd(BASE + 32'h4, 32'h3C, "R6 first byte");
        rd(BASE + 32'h4, 32'h81, "R6 second byte");
        rd(BASE + 32'h4, 32'd0, "R7 drained read");
        rd(BASE + 32'h8, 32'd0, "R6 queue empty");

        // R8: low stop bit discards the frame
        send(8'h55, 1'b0);
        rd(BASE + 32'h8, 32'd0, "R8 bad stop discarded");
        send(8'hC3, 1'b1);
        rd(BASE + 32'h4, 32'hC3, "R8 recovers after bad frame");

        // R9: 17 bytes into 16 entries
        for (int i = 0; i < 17; i++) send(8'(i * 7 + 1), 1'b1);
        rd(BASE + 32'h8, 32'd2, "R9 full status");
        for (int i = 0; i < 16; i++) rd(BASE + 32'h4, 32'(8'(i * 7 + 1)), "R9 order");
        rd(BASE + 32'h8, 32'd0, "R9 17th dropped");

        // R5: writes to read-only registers
        send(8'h42, 1'b1);
        wr(BASE + 32'h8, 32'hFFFF_FFFF);
        wr(BASE + 32'h4, 32'h0000_00EE);
        rd(BASE + 32'h8, 32'd2, "R5 status after ro writes");
        rd(BASE + 32'h4, 32'h42, "R5 rx byte kept");
        rd(BASE + 32'h8, 32'd0, "R5 status final");
        repeat (2 * CPB) @(negedge clk);
        check("R3 line idle at end", {31'd0, tx}, 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule